// File: doc/BRIEF.md
# Double-Buffered Crosspoint Router

A synchronous router with four single-bit data inputs and four registered data outputs. The route of each output is set through a two-step handshake. A rising edge on the load strobe copies the current source address and destination address into a staging register. A later rising edge on the commit strobe writes that staged pair into the active routing table. The active table drives one multiplexer per output, and the outputs are registered behind those multiplexers. Outputs that a commit does not address keep their data without interruption.

After reset the block is in broadcast mode. In this mode the input named by the source address reaches all four outputs, and the destination address and the table are ignored. Both strobes and both addresses rest high when undriven. The block leaves broadcast mode the first time both strobes are sampled low. On that same cycle it fills the table so that every output keeps the source it had in broadcast mode. Only a reset brings the block back to broadcast mode.

The controller has three states. `XR_FANOUT` is broadcast. `XR_IDLE` is crosspoint mode with nothing staged. `XR_STAGED` is crosspoint mode holding a staged pair. The transitions are:
- **enter**: from `XR_FANOUT` to `XR_IDLE` when both strobes are low.
- **stage**: from `XR_IDLE` to `XR_STAGED` on a load edge.
- **restage**: from `XR_STAGED` back to `XR_STAGED` on a load edge.
- **commit**: from `XR_STAGED` to `XR_IDLE` on a commit edge with no load edge in the same cycle.

Top module: `xpoint_router`

## Requirements
- R1: While reset is asserted, every output bit is 0. When reset is released, the block is in broadcast mode.
- R2: In broadcast mode, every output bit equals the input selected by the source address. The destination address and the strobe edges have no effect.
- R3: The source address value k (00, 01, 10, 11) selects data input bit k.
- R4: While in broadcast mode, a clock edge that samples both strobes low moves the block to crosspoint mode. Each table entry is then set to the source address sampled at that edge. After this, the source address no longer affects the outputs until a commit.
- R5: A load edge stages the source and destination addresses sampled at that edge. The outputs keep their current routes.
- R6: A commit edge with a pair staged routes output bit k, where k is the staged destination value, from the staged source. The new route shows on the outputs at the clock edge that follows the edge at which the commit strobe is first sampled high.
- R7: A commit changes only the addressed output. All other outputs keep their routes.
- R8: A commit edge with no load edge since the previous commit, or since entering crosspoint mode, leaves the table unchanged.
- R9: A strobe acts only on a low-to-high transition. Holding a strobe high does not repeat the action. A strobe that is already high when reset is released produces no edge.
- R10: Four load/commit pairs, one for each destination value and all with the same source, send that source to all four outputs in crosspoint mode.
- R11: When two load edges come before a commit, the later pair is the one committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| din | input | 4 | Data inputs, bit k is source k |
| in_sel | input | 2 | Source address |
| out_sel | input | 2 | Destination address |
| load_strb | input | 1 | Stage strobe, rising-edge active |
| cfg_strb | input | 1 | Commit strobe, rising-edge active |
| dout | output | 4 | Registered data outputs |

## Verification
In broadcast mode the bench sweeps every source address with one-hot data and random data. It also toggles the strobes while keeping them from both going low, which shows that the destination address and the strobes are ignored. Directed sequences cover the remaining cases:
- entering crosspoint mode, followed by changes to the source address, which distinguishes a table frozen at entry from a design that still follows the source;
- a commit with nothing staged, and a load held high across several address changes, which show whether actions fire on edges or on levels;
- a double load before one commit;
- a four-pair broadcast rebuilt in crosspoint mode.

A long random run in crosspoint mode then mixes strobe levels, addresses and data. Every cycle is compared against a reference model in the bench, which exposes wrong destination decoding, disturbed neighbouring outputs and commit timing that is off by one cycle.

// File: rtl/xr_pkg.sv
package xr_pkg;
    typedef enum logic [1:0] {
        XR_FANOUT = 2'd0,
        XR_IDLE   = 2'd1,
        XR_STAGED = 2'd2
    } xr_mode_e;
endpackage

// File: rtl/xr_edge.sv
module xr_edge #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev_q;

    // Reset to high: an undriven strobe rests high, so no edge at reset exit.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;

    assert_no_repeat_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != '0) |=> ((rise & $past(rise)) == '0));
endmodule

// File: rtl/xr_cfg_fsm.sv
module xr_cfg_fsm
    import xr_pkg::*;
#(
    parameter int N_PORTS = 4,
    parameter int SEL_W   = $clog2(N_PORTS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [SEL_W-1:0]              in_sel,
    input  logic [SEL_W-1:0]              out_sel,
    input  logic                          load_lvl,
    input  logic                          cfg_lvl,
    input  logic                          load_rise,
    input  logic                          cfg_rise,
    output logic [N_PORTS-1:0][SEL_W-1:0] route,
    output logic                          fanout
);
    xr_mode_e                        state_q, state_d;
    logic [N_PORTS-1:0][SEL_W-1:0]   route_q;
    logic [SEL_W-1:0]                stg_src_q, stg_dst_q;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XR_FANOUT: if (!load_lvl && !cfg_lvl)   state_d = XR_IDLE;   // enter
            XR_IDLE:   if (load_rise)               state_d = XR_STAGED; // stage
            XR_STAGED: if (cfg_rise && !load_rise)  state_d = XR_IDLE;   // commit
            default:                                state_d = XR_FANOUT;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= XR_FANOUT;
        else        state_q <= state_d;
    end

    // Table and staging register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            route_q   <= '0;
            stg_src_q <= '0;
            stg_dst_q <= '0;
        end else begin
            if (state_q == XR_FANOUT && state_d == XR_IDLE) begin
                for (int n = 0; n < N_PORTS; n++) route_q[n] <= in_sel;
            end
            if (state_q == XR_STAGED && cfg_rise) begin
                route_q[stg_dst_q] <= stg_src_q;
            end
            if (state_q != XR_FANOUT && load_rise) begin
                stg_src_q <= in_sel;
                stg_dst_q <= out_sel;
            end
        end
    end

    // Outputs
    always_comb begin
        route  = route_q;
        fanout = (state_q == XR_FANOUT);
    end

    assert_mode_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != XR_FANOUT) |=> (state_q != XR_FANOUT));

    assert_idle_commit_noop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == XR_IDLE && cfg_rise) |=> $stable(route_q));

    assert_load_keeps_table_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != XR_FANOUT && load_rise && !cfg_rise) |=> $stable(route_q));
endmodule

// File: rtl/xr_mux.sv
module xr_mux #(
    parameter int N_PORTS = 4,
    parameter int SEL_W   = $clog2(N_PORTS)
) (
    input  logic [N_PORTS-1:0]            din,
    input  logic [SEL_W-1:0]              in_sel,
    input  logic [N_PORTS-1:0][SEL_W-1:0] route,
    input  logic                          fanout,
    output logic [N_PORTS-1:0]            nxt
);
    for (genvar g = 0; g < N_PORTS; g++) begin : g_out
        logic [SEL_W-1:0] src;
        assign src    = fanout ? in_sel : route[g];
        assign nxt[g] = din[src];
    end
endmodule

// File: rtl/xpoint_router.sv
module xpoint_router #(
    parameter int N_PORTS = 4,
    localparam int SEL_W  = $clog2(N_PORTS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_PORTS-1:0] din,
    input  logic [SEL_W-1:0]   in_sel,
    input  logic [SEL_W-1:0]   out_sel,
    input  logic               load_strb,
    input  logic               cfg_strb,
    output logic [N_PORTS-1:0] dout
);
    logic [1:0]                    rise;
    logic [N_PORTS-1:0][SEL_W-1:0] route;
    logic                          fanout;
    logic [N_PORTS-1:0]            nxt;

    xr_edge #(.W(2)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  ({cfg_strb, load_strb}),
        .rise (rise)
    );

    xr_cfg_fsm #(.N_PORTS(N_PORTS), .SEL_W(SEL_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_sel   (in_sel),
        .out_sel  (out_sel),
        .load_lvl (load_strb),
        .cfg_lvl  (cfg_strb),
        .load_rise(rise[0]),
        .cfg_rise (rise[1]),
        .route    (route),
        .fanout   (fanout)
    );

    xr_mux #(.N_PORTS(N_PORTS), .SEL_W(SEL_W)) u_mux (
        .din   (din),
        .in_sel(in_sel),
        .route (route),
        .fanout(fanout),
        .nxt   (nxt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dout <= '0;
        else        dout <= nxt;
    end

    assert_fanout_uniform_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fanout |=> (dout == '0 || dout == '1));
endmodule

// File: tb/sim_xpoint_router.sv
module sim_xpoint_router;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] din;
    logic [1:0] in_sel, out_sel;
    logic       load_strb, cfg_strb;
    logic [3:0] dout;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 0;
    string cur_req = "R1";

    // reference model state
    bit         m_fan, m_staged, m_pl, m_pc;
    logic [1:0] m_tab [4];
    logic [1:0] m_sin, m_sout;
    logic [3:0] m_exp;

    always #5 clk = ~clk;

    xpoint_router u0 (
        .clk(clk), .rst_n(rst_n), .din(din), .in_sel(in_sel), .out_sel(out_sel),
        .load_strb(load_strb), .cfg_strb(cfg_strb), .dout(dout)
    );

    function automatic logic [3:0] exp_out(input logic [3:0] d, input bit fan,
                                           input logic [1:0] t0, input logic [1:0] t1,
                                           input logic [1:0] t2, input logic [1:0] t3,
                                           input logic [1:0] is);
        logic [3:0] r;
        r[0] = d[fan ? is : t0];
        r[1] = d[fan ? is : t1];
        r[2] = d[fan ? is : t2];
        r[3] = d[fan ? is : t3];
        return r;
    endfunction

    task automatic model_reset();
        m_fan = 1; m_staged = 0; m_pl = 1; m_pc = 1;
        for (int n = 0; n < 4; n++) m_tab[n] = 2'd0;
        m_sin = 0; m_sout = 0; m_exp = 4'h0;
    endtask

    task automatic model_step();
        bit lr, cr;
        if (!rst_n) begin
            model_reset();
            return;
        end
        m_exp = exp_out(din, m_fan, m_tab[0], m_tab[1], m_tab[2], m_tab[3], in_sel);
        lr = load_strb & ~m_pl;
        cr = cfg_strb & ~m_pc;
        if (m_fan) begin
            if (!load_strb && !cfg_strb) begin
                m_fan = 0; m_staged = 0;
                for (int n = 0; n < 4; n++) m_tab[n] = in_sel;
            end
        end else begin
            if (cr && m_staged) begin
                m_tab[m_sout] = m_sin;
                m_staged = 0;
            end
            if (lr) begin
                m_sin = in_sel; m_sout = out_sel; m_staged = 1;
            end
        end
        m_pl = load_strb; m_pc = cfg_strb;
    endtask

    task automatic check(input logic [3:0] expv);
        n_vec++;
        if (dout !== expv) begin
            n_fail++;
            $display("FAIL %s: dout=%b expected=%b at %0t", cur_req, dout, expv, $time);
        end
    endtask

    // one cycle: drive at negedge, clock, sample at next negedge
    task automatic cyc(input logic [3:0] d, input logic [1:0] is, input logic [1:0] os,
                       input logic ld, input logic cf);
        din = d; in_sel = is; out_sel = os; load_strb = ld; cfg_strb = cf;
        @(posedge clk);
        model_step();
        @(negedge clk);
        check(m_exp);
    endtask

    task automatic route(input logic [1:0] src, input logic [1:0] dst);
        cyc(4'($urandom), src, dst, 1'b1, 1'b0);
        cyc(4'($urandom), src, dst, 1'b0, 1'b0);
        cyc(4'($urandom), 2'($urandom), 2'($urandom), 1'b0, 1'b1);
        cyc(4'($urandom), 2'($urandom), 2'($urandom), 1'b0, 1'b0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 0; din = 0; in_sel = 2'b11; out_sel = 2'b11; load_strb = 1; cfg_strb = 1;
        model_reset();
        repeat (3) @(negedge clk);
        cur_req = "R1";                       // R1: reset value
        check(4'h0);
        rst_n = 1;

        cur_req = "R2";                       // R2: broadcast, strobes never both low
        for (int i = 0; i < 60; i++) begin
            logic ld, cf;
            ld = 1'($urandom);
            cf = ld ? 1'($urandom) : 1'b1;
            cyc(4'($urandom), 2'($urandom), 2'($urandom), ld, cf);
        end
        cur_req = "R3";                       // R3: one-hot per source value
        for (int k = 0; k < 4; k++) begin
            cyc(4'(1 << k), 2'(k), 2'($urandom), 1'b1, 1'b1);
            cyc(4'(1 << k), 2'(k), 2'($urandom), 1'b1, 1'b1);
            check(4'hF);
            cyc(~4'(1 << k), 2'(k), 2'($urandom), 1'b1, 1'b1);
            cyc(~4'(1 << k), 2'(k), 2'($urandom), 1'b1, 1'b1);
            check(4'h0);
        end

        cur_req = "R4";                       // R4: enter crosspoint with source 2
        cyc(4'h4, 2'd2, 2'd0, 1'b0, 1'b0);
        for (int i = 0; i < 12; i++)
            cyc(4'($urandom), 2'($urandom), 2'($urandom), 1'b0, 1'b0);
        cyc(4'h4, 2'd0, 2'd1, 1'b0, 1'b0);
        cyc(4'h4, 2'd0, 2'd1, 1'b0, 1'b0);
        check(4'hF);

        cur_req = "R5";                       // R5: load alone keeps routes
        cyc(4'h4, 2'd0, 2'd3, 1'b1, 1'b0);
        cyc(4'h4, 2'd0, 2'd3, 1'b0, 1'b0);
        check(4'hF);
        cur_req = "R6";                       // R6: commit source 0 to output 3
        cyc(4'h1, 2'd1, 2'd1, 1'b0, 1'b1);    // commit edge sampled here
        check(4'h0);                          // old routes still on dout
        cyc(4'h1, 2'd1, 2'd1, 1'b0, 1'b0);
        check(4'h8);                          // new route visible one clock later
        cur_req = "R7";                       // R7: neighbours untouched
        route(2'd1, 2'd0);
        cyc(4'h2, 2'd3, 2'd3, 1'b0, 1'b0);
        cyc(4'h2, 2'd3, 2'd3, 1'b0, 1'b0);
        check(4'h1);

        cur_req = "R8";                       // R8: commit with nothing staged
        cyc(4'($urandom), 2'd3, 2'd2, 1'b0, 1'b1);
        cyc(4'($urandom), 2'd3, 2'd2, 1'b0, 1'b0);
        cyc(4'h4, 2'd3, 2'd2, 1'b0, 1'b0);
        cyc(4'h4, 2'd3, 2'd2, 1'b0, 1'b0);
        check(4'h6);

        cur_req = "R9";                       // R9: load held high over address changes
        cyc(4'($urandom), 2'd3, 2'd1, 1'b1, 1'b0);
        cyc(4'($urandom), 2'd2, 2'd2, 1'b1, 1'b0);
        cyc(4'($urandom), 2'd1, 2'd3, 1'b1, 1'b0);
        cyc(4'($urandom), 2'd1, 2'd3, 1'b0, 1'b1);
        cyc(4'($urandom), 2'd1, 2'd3, 1'b0, 1'b1);
        cyc(4'h8, 2'd0, 2'd0, 1'b0, 1'b0);
        cyc(4'h8, 2'd0, 2'd0, 1'b0, 1'b0);
        check(4'h2);                          // only first pair (3 -> out1) committed

        cur_req = "R11";                      // R11: last load wins
        cyc(4'($urandom), 2'd2, 2'd0, 1'b1, 1'b0);
        cyc(4'($urandom), 2'd2, 2'd0, 1'b0, 1'b0);
        cyc(4'($urandom), 2'd3, 2'd2, 1'b1, 1'b0);
        cyc(4'($urandom), 2'd3, 2'd2, 1'b0, 1'b1);
        cyc(4'($urandom), 2'd3, 2'd2, 1'b0, 1'b0);
        cyc(4'h8, 2'd0, 2'd0, 1'b0, 1'b0);
        cyc(4'h8, 2'd0, 2'd0, 1'b0, 1'b0);
        check(4'h6);

        cur_req = "R10";                      // R10: four pairs rebuild broadcast of source 1
        for (int k = 0; k < 4; k++) route(2'd1, 2'(k));
        cyc(4'h2, 2'd0, 2'd0, 1'b0, 1'b0);
        cyc(4'h2, 2'd0, 2'd0, 1'b0, 1'b0);
        check(4'hF);
        cyc(4'hD, 2'd0, 2'd0, 1'b0, 1'b0);
        cyc(4'hD, 2'd0, 2'd0, 1'b0, 1'b0);
        check(4'h0);

        cur_req = "R6";                       // R6/R7: random crosspoint traffic
        for (int i = 0; i < 3000; i++)
            cyc(4'($urandom), 2'($urandom), 2'($urandom),
                1'($urandom_range(0, 2) == 0), 1'($urandom_range(0, 2) == 0));

        cur_req = "R1";                       // R1: reset mid-run, back to broadcast
        rst_n = 0;
        cyc(4'h5, 2'd0, 2'd0, 1'b1, 1'b1);
        check(4'h0);
        rst_n = 1;
        cur_req = "R2";
        for (int i = 0; i < 40; i++)
            cyc(4'($urandom), 2'($urandom), 2'($urandom), 1'b1, 1'($urandom));

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end
endmodule